// File: doc/BRIEF.md
# Remote GPIO Serial Endpoint

This block is the board-side end of a three-lane serial link that trades one 32-bit GPIO word in each direction with an FPGA. The FPGA drives the serial clock and the inbound data line. The endpoint returns a snapshot of local board inputs on the outbound line. Every frame is exactly 32 serial clocks long and has no frame strobe, so the endpoint finds frame boundaries by counting clock edges.

Each frame carries a 4-bit presence code in its top nibble. The endpoint uses that code to decide whether a live peer is attached. While a peer is present, the eight user LEDs and the two PHY LEDs show bits taken from the inbound word. While no peer is present, they show the local status signals that the rest of the board supplies.

The serial lanes are asynchronous to the system clock. Both are brought into the system clock domain through a two-flop synchronizer, and the serial clock edges are detected there. A silence timer on the serial clock restores frame alignment after a partial frame.

Top module: `rgpio_endpoint`

## Requirements
- R1: The outbound word has these fields:
  - bits 31:28 hold 4'b1010 (4'hA);
  - bits 27:22 and bit 19 are 0;
  - bits 21:20 equal `modio_i[1:0]`;
  - bits 18:0 equal `loc_in_i[18:0]`.
- R2: Outbound bits are sent most significant first on `sdo_o`.
  - Bit 31 is present before the first rising serial clock edge of a frame.
  - Each later bit appears after a falling edge, so the peer can sample on each rising edge.
- R3: The outbound word is a snapshot taken when the first rising edge of a frame arrives. Input changes later in the same frame do not alter that frame.
- R4: At the completion of a frame (the 32nd rising edge) whose bits 31:28 equal 4'hA:
  - inbound bits 7:0 drive `user_led_o[7:0]`;
  - inbound bits 9:8 drive `phy_led_o[1:0]`.
  - These values then hold until the next such frame.
- R5: Inbound bits 27:10 have no effect on any output.
- R6: One completed frame with presence code 4'hA sets `link_up_o` to 1.
- R7: Invalid frames drop the link as follows:
  - a single frame whose code is not 4'hA leaves `link_up_o` and the LEDs unchanged;
  - two such frames in a row set `link_up_o` to 0;
  - a valid frame in between clears the count.
- R8: If no serial clock edge arrives for 2^16 system clocks, `link_up_o` goes to 0 and the bit count returns to the frame start, which discards any partial frame.
- R9: Behaviour depends on the link state:
  - while `link_up_o` is 0, the LEDs follow `loc_led_i` and `loc_phy_i` one system clock later;
  - while it is 1, the LEDs change only at the completion of a valid frame.
- R10: After reset:
  - `link_up_o` is 0;
  - the LEDs show local status;
  - the next rising edge starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the FPGA |
| sdi_i | input | 1 | Serial data from the FPGA |
| sdo_o | output | 1 | Serial data to the FPGA |
| loc_in_i | input | 19 | Local inputs placed in outbound bits 18:0 |
| modio_i | input | 2 | Module IO inputs placed in outbound bits 21:20 |
| loc_led_i | input | 8 | Local status for the user LEDs |
| loc_phy_i | input | 2 | Local status for the PHY LEDs |
| user_led_o | output | 8 | User LED drive |
| phy_led_o | output | 2 | PHY LED drive |
| link_up_o | output | 1 | Peer present |

## Verification
The bench targets the following corner cases, each with the symptom a wrong design would show:
- **Link hysteresis edge.** A single bad presence code must not drop the link, and a good frame between two bad ones must clear the count. A design that counts wrong loses the link one frame early or keeps it one frame too long.
- **Mid-frame input change.** Local inputs change halfway through a frame. A design that keeps reloading its shift register sends a mixed word.
- **Ignored inbound fields.** A frame sets every ignored bit to 1. A design that is off by one in its field slicing would light a wrong LED.
- **Silence timer.** The bench checks the link just before and just after the 2^16-cycle limit. It also sends a ten-bit partial frame followed by silence. A design that does not realign reads the next full frame shifted, so both the LEDs and the presence code come out wrong.

// File: rtl/rgpio_pkg.sv
package rgpio_pkg;

    localparam int FRAME_W     = 32;
    localparam int DET_W       = 4;
    localparam logic [DET_W-1:0] DET_VALID = 4'hA;
    localparam int LOC_W       = 19;
    localparam int MODIO_W     = 2;
    localparam int ULED_W      = 8;
    localparam int PHY_W       = 2;
    localparam int LED_W       = ULED_W + PHY_W;
    localparam int CNT_W       = $clog2(FRAME_W);

    // Outbound word layout, most significant field first.
    typedef struct packed {
        logic [DET_W-1:0]   det;
        logic [3:0]         rsvd;
        logic [1:0]         spare_hi;
        logic [MODIO_W-1:0] modio;
        logic               spare_lo;
        logic [LOC_W-1:0]   loc;
    } tx_frame_t;

    // LED drive word: PHY bits above the user bits, as in inbound bits 9:0.
    typedef struct packed {
        logic [PHY_W-1:0]  phy;
        logic [ULED_W-1:0] uled;
    } led_word_t;

    typedef enum logic {LINK_DOWN = 1'b0, LINK_UP = 1'b1} link_state_t;

    function automatic tx_frame_t build_tx(input logic [LOC_W-1:0]   loc,
                                           input logic [MODIO_W-1:0] mio);
        tx_frame_t f;
        f.det      = DET_VALID;
        f.rsvd     = '0;
        f.spare_hi = '0;
        f.modio    = mio;
        f.spare_lo = 1'b0;
        f.loc      = loc;
        return f;
    endfunction

    function automatic logic det_ok(input logic [DET_W-1:0] d);
        return d == DET_VALID;
    endfunction

endpackage

// File: rtl/rgpio_sync.sv
module rgpio_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rgpio_silence.sv
module rgpio_silence #(
    parameter int TMO_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    output logic tmo_o
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || edge_i) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    // Fires on the 2^TMO_W-th consecutive cycle without an edge.
    assign tmo_o = (cnt_q == '1) && !edge_i;
endmodule

// File: rtl/rgpio_shifter.sv
module rgpio_shifter
    import rgpio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rise_i,
    input  logic                  fall_i,
    input  logic                  sdi_i,
    input  logic                  resync_i,
    input  tx_frame_t             snap_i,
    output logic                  sdo_o,
    output logic                  frame_done_o,
    output logic [DET_W-1:0]      frame_det_o,
    output led_word_t             frame_led_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-2:0] rx_q;
    logic [FRAME_W-1:0] tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rx_q  <= '0;
            tx_q  <= '0;
        end else begin
            if (resync_i)    cnt_q <= '0;
            else if (rise_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

            if (rise_i) rx_q <= {rx_q[FRAME_W-3:0], sdi_i};

            // Idle between frames: keep loading; first rising edge freezes it.
            if (cnt_q == '0 && !rise_i)
                tx_q <= snap_i;
            else if (fall_i && cnt_q != '0)
                tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign sdo_o        = tx_q[FRAME_W-1];
    assign frame_done_o = rise_i && (cnt_q == LAST) && !resync_i;
    assign frame_det_o  = rx_q[FRAME_W-2 -: DET_W];
    assign frame_led_o  = {rx_q[LED_W-2:0], sdi_i};
endmodule

// File: rtl/rgpio_link.sv
module rgpio_link #(
    parameter int DROP_FRAMES = 2,
    parameter int BAD_W       = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_done_i,
    input  logic             frame_ok_i,
    input  logic             tmo_i,
    output logic             active_o,
    output logic             active_nx_o,
    output logic [BAD_W-1:0] bad_o
);
    import rgpio_pkg::*;

    link_state_t      st_q, st_d;
    logic [BAD_W-1:0] bad_q, bad_d;

    always_comb begin
        st_d  = st_q;
        bad_d = bad_q;
        if (tmo_i) begin
            st_d  = LINK_DOWN;
            bad_d = '0;
        end else if (frame_done_i) begin
            if (frame_ok_i) begin
                st_d  = LINK_UP;
                bad_d = '0;
            end else if (bad_q == BAD_W'(DROP_FRAMES - 1)) begin
                st_d  = LINK_DOWN;
                bad_d = '0;
            end else begin
                bad_d = bad_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LINK_DOWN;
            bad_q <= '0;
        end else begin
            st_q  <= st_d;
            bad_q <= bad_d;
        end
    end

    assign active_o    = (st_q == LINK_UP);
    assign active_nx_o = (st_d == LINK_UP);
    assign bad_o       = bad_q;
endmodule

// File: rtl/rgpio_endpoint.sv
module rgpio_endpoint
    import rgpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TMO_W       = 16,
    parameter int DROP_FRAMES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_i,
    input  logic               sdi_i,
    output logic               sdo_o,
    input  logic [LOC_W-1:0]   loc_in_i,
    input  logic [MODIO_W-1:0] modio_i,
    input  logic [ULED_W-1:0]  loc_led_i,
    input  logic [PHY_W-1:0]   loc_phy_i,
    output logic [ULED_W-1:0]  user_led_o,
    output logic [PHY_W-1:0]   phy_led_o,
    output logic               link_up_o
);
    localparam int BAD_W = $clog2(DROP_FRAMES + 1);

    logic [1:0]       lane_s;
    logic             sclk_s, sdi_s, sclk_q;
    logic             rise, fall, tmo_hit;
    logic             frame_done, active_nx;
    logic [DET_W-1:0] frame_det;
    led_word_t        frame_led, local_led, led_q;
    logic [BAD_W-1:0] bad_cnt;
    tx_frame_t        snap;

    rgpio_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d_i({sclk_i, sdi_i}), .q_o(lane_s)
    );
    assign sclk_s = lane_s[1];
    assign sdi_s  = lane_s[0];

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_s;
    end
    assign rise = sclk_s & ~sclk_q;
    assign fall = ~sclk_s & sclk_q;

    rgpio_silence #(.TMO_W(TMO_W)) sil_i (
        .clk(clk), .rst(rst), .edge_i(rise | fall), .tmo_o(tmo_hit)
    );

    assign snap = build_tx(loc_in_i, modio_i);

    rgpio_shifter shf_i (
        .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall), .sdi_i(sdi_s),
        .resync_i(tmo_hit), .snap_i(snap), .sdo_o(sdo_o),
        .frame_done_o(frame_done), .frame_det_o(frame_det), .frame_led_o(frame_led)
    );

    rgpio_link #(.DROP_FRAMES(DROP_FRAMES), .BAD_W(BAD_W)) lnk_i (
        .clk(clk), .rst(rst), .frame_done_i(frame_done),
        .frame_ok_i(det_ok(frame_det)), .tmo_i(tmo_hit),
        .active_o(link_up_o), .active_nx_o(active_nx), .bad_o(bad_cnt)
    );

    assign local_led = '{phy: loc_phy_i, uled: loc_led_i};

    always_ff @(posedge clk) begin
        if (rst || !active_nx)
            led_q <= local_led;
        else if (frame_done && det_ok(frame_det))
            led_q <= frame_led;
    end

    assign user_led_o = led_q.uled;
    assign phy_led_o  = led_q.phy;
endmodule

// File: rtl/rgpio_endpoint_chk.sv
module rgpio_endpoint_chk
    import rgpio_pkg::*;
#(
    parameter int DROP_FRAMES = 2,
    parameter int BAD_W       = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_done,
    input logic [DET_W-1:0] frame_det,
    input led_word_t        frame_led,
    input logic             tmo_hit,
    input logic [BAD_W-1:0] bad_cnt,
    input logic             link_up_o,
    input logic [ULED_W-1:0] user_led_o,
    input logic [PHY_W-1:0] phy_led_o
);
    a_r6_valid_frame_raises_link: assert property (@(posedge clk) disable iff (rst)
        (frame_done && det_ok(frame_det) && !tmo_hit) |=> link_up_o);

    a_r4_leds_take_remote: assert property (@(posedge clk) disable iff (rst)
        (frame_done && det_ok(frame_det) && !tmo_hit) |=> ({phy_led_o, user_led_o} == $past(frame_led)));

    a_r7_single_bad_keeps_link: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !det_ok(frame_det) && !tmo_hit && link_up_o &&
         bad_cnt < BAD_W'(DROP_FRAMES - 1)) |=> link_up_o);

    a_r7_bad_run_drops_link: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !det_ok(frame_det) && !tmo_hit &&
         bad_cnt == BAD_W'(DROP_FRAMES - 1)) |=> !link_up_o);

    a_r8_silence_drops_link: assert property (@(posedge clk) disable iff (rst)
        tmo_hit |=> !link_up_o);

    a_r9_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
        (link_up_o && !frame_done && !tmo_hit) |=> $stable({phy_led_o, user_led_o}));

    a_r10_reset_link_down: assert property (@(posedge clk)
        rst |=> !link_up_o);
endmodule

bind rgpio_endpoint rgpio_endpoint_chk #(.DROP_FRAMES(DROP_FRAMES), .BAD_W(BAD_W)) chk_i (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_det(frame_det),
    .frame_led(frame_led), .tmo_hit(tmo_hit), .bad_cnt(bad_cnt),
    .link_up_o(link_up_o), .user_led_o(user_led_o), .phy_led_o(phy_led_o)
);

// File: tb/rgpio_endpoint_tb_top.sv
module rgpio_endpoint_tb_top;
    localparam int H = 6;  // system clocks per serial clock half period

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, sclk, sdi, sdo, link;
    logic [18:0] loc_in;
    logic [1:0]  mio, loc_phy, phy;
    logic [7:0]  loc_led, uled;

    rgpio_endpoint dut_i (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo),
        .loc_in_i(loc_in), .modio_i(mio), .loc_led_i(loc_led), .loc_phy_i(loc_phy),
        .user_led_o(uled), .phy_led_o(phy), .link_up_o(link)
    );

    typedef struct {
        string       req;
        logic        link;
        logic [7:0]  uled;
        logic [1:0]  phy;
        logic [31:0] tx;
    } exp_t;

    exp_t        q[$];
    event        frame_ev;
    logic [31:0] cap;
    int          checks = 0, errors = 0;
    logic        m_link = 1'b0;
    int          m_bad  = 0;
    logic [9:0]  m_leds = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_tx(input logic [18:0] l, input logic [1:0] m);
        return {4'hA, 4'h0, 2'b00, m, 1'b0, l};
    endfunction

    task automatic send_bits(input logic [31:0] w, input int n);
        logic [18:0] saved = loc_in;
        cap = '0;
        for (int i = 31; i > 31 - n; i--) begin
            @(negedge clk);
            sdi = w[i];
            repeat (H) @(negedge clk);
            cap = {cap[30:0], sdo};
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
            if (i == 25) loc_in = ~saved;  // R3: mid-frame change
        end
        loc_in = saved;
    endtask

    task automatic frame(input logic [31:0] w, input string req);
        exp_t it;
        it.tx  = exp_tx(loc_in, mio);
        it.req = req;
        if (w[31:28] == 4'hA) begin
            m_link = 1'b1; m_bad = 0; m_leds = w[9:0];
        end else begin
            m_bad++;
            if (m_bad >= 2) begin m_link = 1'b0; m_bad = 0; end
        end
        it.link = m_link;
        it.uled = m_link ? m_leds[7:0] : loc_led;
        it.phy  = m_link ? m_leds[9:8] : loc_phy;
        q.push_back(it);
        send_bits(w, 32);
        repeat (8) @(negedge clk);
        -> frame_ev;
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: pops expected items and compares against design outputs.
    initial begin
        forever begin
            exp_t it;
            @(frame_ev);
            it = q.pop_front();
            chk(link == it.link, it.req, "link_up", 32'(link), 32'(it.link));
            chk(uled == it.uled, it.req, "user_led", 32'(uled), 32'(it.uled));
            chk(phy == it.phy, it.req, "phy_led", 32'(phy), 32'(it.phy));
            chk(cap == it.tx, "R1/R2/R3", "outbound word", cap, it.tx);
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; sclk = 1'b0; sdi = 1'b0;
        loc_in = 19'h5A5A5; mio = 2'b10; loc_led = 8'h3C; loc_phy = 2'b01;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(link == 1'b0, "R10", "link after reset", 32'(link), 0);
        chk(uled == 8'h3C && phy == 2'b01, "R10", "local leds after reset",
            {22'd0, phy, uled}, 32'h13C);

        loc_led = 8'hC3; loc_phy = 2'b10;
        repeat (3) @(negedge clk);
        chk(uled == 8'hC3 && phy == 2'b10, "R9", "inactive tracks local",
            {22'd0, phy, uled}, 32'h2C3);

        frame(32'h5000_0011, "R7 invalid while down");
        frame(32'hA000_03A5, "R6");
        loc_led = 8'h0F; loc_phy = 2'b01;
        repeat (20) @(negedge clk);
        chk(uled == 8'hA5 && phy == 2'b11, "R9", "hold while active",
            {22'd0, phy, uled}, 32'h3A5);

        frame(32'hAFFF_FD5A, "R5");
        mio = 2'b01; loc_in = 19'h01234;
        frame(32'h0000_03FF, "R7 single bad");
        frame(32'hA000_0266, "R7 good clears");
        frame(32'h3000_0000, "R7 bad one");
        frame(32'hB000_0001, "R7 bad two");
        frame(32'hA000_01C7, "R4");

        repeat (65000) @(negedge clk);
        chk(link == 1'b1, "R8", "link before limit", 32'(link), 1);
        repeat (1000) @(negedge clk);
        chk(link == 1'b0, "R8", "link after limit", 32'(link), 0);
        chk(uled == loc_led && phy == loc_phy, "R8", "local leds after silence",
            {22'd0, phy, uled}, {22'd0, loc_phy, loc_led});
        m_link = 1'b0; m_bad = 0;

        frame(32'hA000_0155, "R6 relink");
        send_bits(32'hA000_0099, 10);
        repeat (66000) @(negedge clk);
        m_link = 1'b0; m_bad = 0;
        chk(link == 1'b0, "R8", "link after partial frame", 32'(link), 0);
        loc_in = 19'h7_0F0F; mio = 2'b11;
        frame(32'hA000_0312, "R8 realigned");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule